// File: doc/BRIEF.md
# Linked-List Descriptor DMA Engine

This block moves data between two word-addressed memories, a host-side memory and a local memory. It takes its work from a linked list of descriptors that it reads from those same memories. Software loads a pointer register with the address of the first descriptor, selects chaining mode, holds the enable bit and pulses go. The engine then repeats one cycle of work. It reads a four-word descriptor, copies the block it names one 32-bit word at a time, can zero the descriptor's count field, and then follows the link to the next descriptor. It stops after the descriptor whose link word carries the end-of-chain flag.

The two low bits of every pointer choose where the next descriptor lives, so a single chain can use both memories. Each descriptor sets its own copy direction and its own per-block interrupt. An abort input ends a running chain early. Both memory ports use a simple request/acknowledge handshake: a request holds until it is acknowledged, and read data is valid in the acknowledge cycle.

Top module: `chain_dma`

## Requirements
- R1: A go pulse starts a chain only when the engine is idle and both `enable` and `chain_mode` are 1. A go pulse in any other situation is ignored, and a go pulse while busy does not restart the engine.
- R2: A descriptor is four words read in this order from base = pointer with its low four bits cleared: +0 host address, +4 local address, +8 byte count, +12 link word. It is read from host memory when pointer bit 0 is 1 and from local memory when bit 0 is 0.
- R3: Link word flags: bit 0 gives the next descriptor's memory (1 = host), bit 1 marks end of chain, bit 2 requests a block interrupt, and bit 3 gives the direction (1 = local to host, 0 = host to local).
- R4: A block of N bytes (N a multiple of 4) is N/4 read-then-write word pairs. Both addresses step by 4 after each word.
- R5: A byte count of zero completes the block with no data access.
- R6: The engine follows link words through any number of descriptors, in either memory, until the descriptor marked end of chain is complete.
- R7: `blk_irq` pulses for one cycle after each completed block whose link word has bit 2 set.
- R8: At the end of a chain `done_irq` pulses for one cycle and `done` becomes 1. `done` returns to 0 when the next go pulse is accepted.
- R9: When `clr_cnt` is 1 and the descriptor lives in local memory, the engine writes 0 to the descriptor's count word after the block. A descriptor held in host memory is never rewritten.
- R10: An `abort` pulse while busy stops the engine once the current word is complete. No further descriptors are read, and `done` is set.
- R11: At most one memory port requests at a time. A request keeps its address and write enable stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptr_wr | input | 1 | Load the first-descriptor pointer register |
| ptr_wdata | input | 32 | Pointer value (bit 0 selects the memory) |
| chain_mode | input | 1 | Chaining mode selected |
| enable | input | 1 | Channel enable |
| go | input | 1 | Start pulse |
| abort | input | 1 | Abort pulse |
| clr_cnt | input | 1 | Zero the count field after each local block |
| busy | output | 1 | Chain in progress |
| done | output | 1 | Chain-complete status |
| blk_irq | output | 1 | Per-block interrupt pulse |
| done_irq | output | 1 | Chain-complete interrupt pulse |
| pci_req | output | 1 | Host memory request |
| pci_we | output | 1 | Host memory write enable |
| pci_addr | output | 32 | Host memory byte address |
| pci_wdata | output | 32 | Host memory write data |
| pci_ack | input | 1 | Host memory acknowledge |
| pci_rdata | input | 32 | Host memory read data |
| loc_req | output | 1 | Local memory request |
| loc_we | output | 1 | Local memory write enable |
| loc_addr | output | 32 | Local memory byte address |
| loc_wdata | output | 32 | Local memory write data |
| loc_ack | input | 1 | Local memory acknowledge |
| loc_rdata | input | 32 | Local memory read data |

## Verification
The bench counts every memory access. A zero-count block must cost exactly the four descriptor reads; an engine that copied one word anyway, or wrapped the count, would show extra accesses or a flood of writes. A mixed chain, with one host-resident descriptor copying in one direction and one local descriptor copying in the other, catches swapped direction or location flags, and a wrong memory selection would bring back garbage links. An abort in the middle of a block must leave a following descriptor's target untouched and still raise `done`. A go pulse during a run, and one with the enable bit low, must change nothing.

// File: rtl/chain_dma_pkg.sv
package chain_dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_XFER,
    ST_WBACK,
    ST_NEXT,
    ST_DONE
  } dma_state_e;

  localparam int FLG_LOC = 0;
  localparam int FLG_EOC = 1;
  localparam int FLG_IRQ = 2;
  localparam int FLG_DIR = 3;
endpackage

// File: rtl/chain_dma_port_mux.sv
module chain_dma_port_mux #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         m_req,
  input  logic         m_we,
  input  logic         m_pci,
  input  logic [W-1:0] m_addr,
  input  logic [W-1:0] m_wdata,
  output logic         m_ack,
  output logic [W-1:0] m_rdata,
  output logic         pci_req,
  output logic         pci_we,
  output logic [W-1:0] pci_addr,
  output logic [W-1:0] pci_wdata,
  input  logic         pci_ack,
  input  logic [W-1:0] pci_rdata,
  output logic         loc_req,
  output logic         loc_we,
  output logic [W-1:0] loc_addr,
  output logic [W-1:0] loc_wdata,
  input  logic         loc_ack,
  input  logic [W-1:0] loc_rdata
);
  always_comb begin
    pci_req   = m_req & m_pci;
    loc_req   = m_req & ~m_pci;
    pci_we    = m_we;
    loc_we    = m_we;
    pci_addr  = m_addr;
    loc_addr  = m_addr;
    pci_wdata = m_wdata;
    loc_wdata = m_wdata;
    m_ack     = m_pci ? pci_ack : loc_ack;
    m_rdata   = m_pci ? pci_rdata : loc_rdata;
  end

  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    !(pci_req && loc_req)); // R11
  AST_PCI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pci_req && !pci_ack) |=> (pci_req && $stable(pci_addr) && $stable(pci_we))); // R11
  AST_LOC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_req && !loc_ack) |=> (loc_req && $stable(loc_addr) && $stable(loc_we))); // R11
endmodule

// File: rtl/chain_dma_ctrl.sv
module chain_dma_ctrl
  import chain_dma_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] first_ptr,
  input  logic         abort,
  input  logic         clr_cnt,
  output logic         busy,
  output logic         done,
  output logic         blk_irq,
  output logic         done_irq,
  output logic         m_req,
  output logic         m_we,
  output logic         m_pci,
  output logic [W-1:0] m_addr,
  output logic [W-1:0] m_wdata,
  input  logic         m_ack,
  input  logic [W-1:0] m_rdata
);
  localparam int BPW = W / 8;
  localparam int LG_BPW = $clog2(BPW);
  localparam logic [W-1:0] STEP = W'(BPW);
  localparam logic [W-1:0] DESC_MASK = ~(W'(4 * BPW) - W'(1));

  dma_state_e state_q, state_d;
  logic [1:0]   widx_q, widx_d;
  logic [W-1:0] hst_a_q, hst_a_d, loc_a_q, loc_a_d, cnt_q, cnt_d;
  logic [W-1:0] link_q, link_d, cur_q, cur_d, data_q, data_d;
  logic         wr_ph_q, wr_ph_d, abort_q, abort_d, done_q, done_d;
  logic         abort_any, need_wb, dir_l2h;
  logic [W-1:0] desc_base;

  assign abort_any = abort_q | abort;
  assign need_wb   = clr_cnt & ~cur_q[FLG_LOC];
  assign dir_l2h   = link_q[FLG_DIR];
  assign desc_base = cur_q & DESC_MASK;

  always_comb begin
    state_d = state_q; widx_d = widx_q; hst_a_d = hst_a_q; loc_a_d = loc_a_q;
    cnt_d = cnt_q; link_d = link_q; cur_d = cur_q; data_d = data_q;
    wr_ph_d = wr_ph_q; done_d = done_q;
    abort_d = abort_q | (abort & (state_q != ST_IDLE));
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_FETCH; cur_d = first_ptr; widx_d = '0;
        done_d = 1'b0; abort_d = 1'b0;
      end
      ST_FETCH: if (m_ack) begin
        unique case (widx_q)
          2'd0: hst_a_d = m_rdata;
          2'd1: loc_a_d = m_rdata;
          2'd2: cnt_d   = m_rdata;
          default: link_d = m_rdata;
        endcase
        widx_d = widx_q + 2'd1;
        if (abort_any) state_d = ST_DONE;
        else if (widx_q == 2'd3) begin
          wr_ph_d = 1'b0;
          state_d = (cnt_q == '0) ? ST_WBACK : ST_XFER;
        end
      end
      ST_XFER: if (m_ack) begin
        if (!wr_ph_q) begin
          data_d = m_rdata; wr_ph_d = 1'b1;
        end else begin
          wr_ph_d = 1'b0;
          hst_a_d = hst_a_q + STEP;
          loc_a_d = loc_a_q + STEP;
          cnt_d   = cnt_q - STEP;
          if (abort_any) state_d = ST_DONE;
          else if (cnt_q <= STEP) state_d = ST_WBACK;
        end
      end
      ST_WBACK: if (!need_wb || m_ack) state_d = ST_NEXT;
      ST_NEXT: begin
        if (abort_any || link_q[FLG_EOC]) state_d = ST_DONE;
        else begin
          state_d = ST_FETCH; cur_d = link_q; widx_d = '0;
        end
      end
      ST_DONE: begin
        done_d = 1'b1; state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    m_req = 1'b0; m_we = 1'b0; m_pci = 1'b0; m_addr = '0; m_wdata = '0;
    unique case (state_q)
      ST_FETCH: begin
        m_req  = 1'b1;
        m_pci  = cur_q[FLG_LOC];
        m_addr = desc_base + (W'(widx_q) << LG_BPW);
      end
      ST_XFER: begin
        m_req   = 1'b1;
        m_we    = wr_ph_q;
        m_pci   = wr_ph_q ? dir_l2h : ~dir_l2h;
        m_addr  = (m_pci) ? hst_a_q : loc_a_q;
        m_wdata = data_q;
      end
      ST_WBACK: begin
        m_req  = need_wb;
        m_we   = 1'b1;
        m_addr = desc_base + (W'(2) << LG_BPW);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; widx_q <= '0; hst_a_q <= '0; loc_a_q <= '0;
      cnt_q <= '0; link_q <= '0; cur_q <= '0; data_q <= '0;
      wr_ph_q <= 1'b0; abort_q <= 1'b0; done_q <= 1'b0;
    end else begin
      state_q <= state_d; widx_q <= widx_d; hst_a_q <= hst_a_d; loc_a_q <= loc_a_d;
      cnt_q <= cnt_d; link_q <= link_d; cur_q <= cur_d; data_q <= data_d;
      wr_ph_q <= wr_ph_d; abort_q <= abort_d; done_q <= done_d;
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign blk_irq  = (state_q == ST_NEXT) & link_q[FLG_IRQ];
  assign done_irq = (state_q == ST_DONE);

  AST_ZERO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FETCH && m_ack && widx_q == 2'd3 && !abort_any && cnt_q == '0)
      |=> (state_q == ST_WBACK)); // R5
  AST_WB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WBACK && m_req) |-> (m_we && !m_pci && m_wdata == '0 && clr_cnt)); // R9
  AST_ABORT_NOFETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_q && state_q == ST_NEXT) |=> (state_q == ST_DONE)); // R10
endmodule

// File: rtl/chain_dma.sv
module chain_dma #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ptr_wr,
  input  logic [W-1:0] ptr_wdata,
  input  logic         chain_mode,
  input  logic         enable,
  input  logic         go,
  input  logic         abort,
  input  logic         clr_cnt,
  output logic         busy,
  output logic         done,
  output logic         blk_irq,
  output logic         done_irq,
  output logic         pci_req,
  output logic         pci_we,
  output logic [W-1:0] pci_addr,
  output logic [W-1:0] pci_wdata,
  input  logic         pci_ack,
  input  logic [W-1:0] pci_rdata,
  output logic         loc_req,
  output logic         loc_we,
  output logic [W-1:0] loc_addr,
  output logic [W-1:0] loc_wdata,
  input  logic         loc_ack,
  input  logic [W-1:0] loc_rdata
);
  logic [W-1:0] ptr_q;
  logic         start;
  logic         m_req, m_we, m_pci, m_ack;
  logic [W-1:0] m_addr, m_wdata, m_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_wr) ptr_q <= ptr_wdata;
  end

  assign start = go & enable & chain_mode & ~busy;

  chain_dma_ctrl #(.W(W)) ctrl_i (
    .clk, .rst_n, .start, .first_ptr(ptr_q), .abort, .clr_cnt,
    .busy, .done, .blk_irq, .done_irq,
    .m_req, .m_we, .m_pci, .m_addr, .m_wdata, .m_ack, .m_rdata
  );

  chain_dma_port_mux #(.W(W)) mux_i (
    .clk, .rst_n, .m_req, .m_we, .m_pci, .m_addr, .m_wdata, .m_ack, .m_rdata,
    .pci_req, .pci_we, .pci_addr, .pci_wdata, .pci_ack, .pci_rdata,
    .loc_req, .loc_we, .loc_addr, .loc_wdata, .loc_ack, .loc_rdata
  );

  AST_GO_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && go && enable && chain_mode) |=> (busy && !done)); // R1
  AST_GO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && go && !(enable && chain_mode)) |=> !busy); // R1
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8
  AST_IRQ_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> (done && !busy)); // R8
endmodule

// File: tb/chain_dma_tb_top.sv
module chain_dma_tb_top;
  localparam int W = 32;
  logic clk, rst_n;
  logic ptr_wr, chain_mode, enable, go, abort, clr_cnt;
  logic [W-1:0] ptr_wdata;
  logic busy, done, blk_irq, done_irq;
  logic pci_req, pci_we, pci_ack, loc_req, loc_we, loc_ack;
  logic [W-1:0] pci_addr, pci_wdata, pci_rdata, loc_addr, loc_wdata, loc_rdata;

  logic [31:0] pmem [256];
  logic [31:0] lmem [256];
  int n_acc, n_lwr, n_blk, n_dirq;
  int n_chk, n_fail;
  bit finished;

  chain_dma #(.W(W)) dut_i (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pci_ack <= 1'b0; loc_ack <= 1'b0; pci_rdata <= '0; loc_rdata <= '0;
    end else begin
      if (pci_req && !pci_ack) begin
        pci_ack <= 1'b1;
        if (pci_we) pmem[pci_addr[9:2]] <= pci_wdata;
        else        pci_rdata <= pmem[pci_addr[9:2]];
      end else pci_ack <= 1'b0;
      if (loc_req && !loc_ack) begin
        loc_ack <= 1'b1;
        if (loc_we) lmem[loc_addr[9:2]] <= loc_wdata;
        else        loc_rdata <= lmem[loc_addr[9:2]];
      end else loc_ack <= 1'b0;
    end
  end

  always @(posedge clk) begin
    if (pci_req && pci_ack) n_acc++;
    if (loc_req && loc_ack) begin
      n_acc++;
      if (loc_we) n_lwr++;
    end
    if (blk_irq) n_blk++;
    if (done_irq) n_dirq++;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic set_desc(input bit in_pci, input int base, input logic [31:0] ha,
                          input logic [31:0] la, input logic [31:0] cnt, input logic [31:0] link);
    for (int i = 0; i < 4; i++) begin
      logic [31:0] v;
      v = (i == 0) ? ha : (i == 1) ? la : (i == 2) ? cnt : link;
      if (in_pci) pmem[base/4 + i] = v;
      else        lmem[base/4 + i] = v;
    end
  endtask

  task automatic launch(input logic [31:0] ptr);
    @(negedge clk); ptr_wr = 1; ptr_wdata = ptr;
    @(negedge clk); ptr_wr = 0; go = 1;
    @(negedge clk); go = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
    chk(!busy, "R6 engine stuck busy", 32'(busy), 0);
  endtask

  task automatic t_reset();
    chk(!busy && !done, "R8 reset idle", {busy, done}, 0);
    chk(!pci_req && !loc_req, "R11 reset no request", {pci_req, loc_req}, 0);
  endtask

  task automatic t_single();
    int a0, d0;
    for (int i = 0; i < 4; i++) begin pmem[128 + i] = 32'hA000_0000 + i; lmem[192 + i] = 32'h5EED; end
    set_desc(0, 'h100, 'h200, 'h300, 12, 32'h2);
    a0 = n_acc; d0 = n_dirq;
    launch('h100);
    wait_idle();
    for (int i = 0; i < 3; i++)
      chk(lmem[192 + i] == 32'hA000_0000 + i, "R4 host-to-local word", lmem[192 + i], 32'hA000_0000 + i);
    chk(lmem[195] == 32'h5EED, "R4 word past block untouched", lmem[195], 32'h5EED);
    chk(n_acc - a0 == 10, "R2 four fetches plus six data accesses", n_acc - a0, 10);
    chk(done == 1, "R8 done set", 32'(done), 1);
    chk(n_dirq - d0 == 1, "R8 one done_irq", n_dirq - d0, 1);
  endtask

  task automatic t_chain();
    int a0, b0;
    lmem[224] = 32'h1111_0001; lmem[225] = 32'h1111_0002; pmem[176] = 32'h2222_0003;
    set_desc(1, 'h040, 'h280, 'h380, 8, 32'h14C);
    set_desc(0, 'h140, 'h2C0, 'h3C0, 4, 32'h6);
    a0 = n_acc; b0 = n_blk;
    launch('h041);
    wait_idle();
    chk(pmem[160] == 32'h1111_0001, "R3 local-to-host word0", pmem[160], 32'h1111_0001);
    chk(pmem[161] == 32'h1111_0002, "R3 local-to-host word1", pmem[161], 32'h1111_0002);
    chk(lmem[240] == 32'h2222_0003, "R6 second descriptor from local memory", lmem[240], 32'h2222_0003);
    chk(n_blk - b0 == 2, "R7 block interrupts", n_blk - b0, 2);
    chk(n_acc - a0 == 14, "R6 access count of mixed chain", n_acc - a0, 14);
  endtask

  task automatic t_zero();
    int a0;
    set_desc(0, 'h180, 'h200, 'h300, 0, 32'h2);
    a0 = n_acc;
    launch('h180);
    wait_idle();
    chk(n_acc - a0 == 4, "R5 zero count makes no data access", n_acc - a0, 4);
    chk(done == 1, "R5 zero block completes chain", 32'(done), 1);
  endtask

  task automatic t_clear();
    int a0;
    clr_cnt = 1;
    pmem[132] = 32'h77;
    set_desc(0, 'h1C0, 'h210, 'h3E0, 4, 32'h2);
    launch('h1C0);
    wait_idle();
    chk(lmem[114] == 0, "R9 local count cleared", lmem[114], 0);
    chk(lmem[248] == 32'h77, "R9 data still moved", lmem[248], 32'h77);
    set_desc(1, 'h0C0, 'h210, 'h3E4, 4, 32'h2);
    a0 = n_acc;
    launch('h0C1);
    wait_idle();
    chk(pmem[50] == 4, "R9 host-resident count kept", pmem[50], 4);
    chk(n_acc - a0 == 6, "R9 no write-back for host descriptor", n_acc - a0, 6);
    clr_cnt = 0;
  endtask

  task automatic t_ignore();
    int d0;
    enable = 0;
    launch('h100);
    chk(!busy && done, "R1 go ignored with enable low", {busy, done}, 1);
    enable = 1; chain_mode = 0;
    launch('h100);
    chk(!busy && done, "R1 go ignored outside chaining mode", {busy, done}, 1);
    chain_mode = 1;
    for (int i = 0; i < 8; i++) begin pmem[192 + i] = 32'hC0DE_0000 + i; lmem[208 + i] = 0; end
    set_desc(0, 'h1E0, 'h300, 'h340, 32, 32'h2);
    set_desc(0, 'h1D0, 'h200, 'h300, 0, 32'h2);
    d0 = n_dirq;
    launch('h1E0);
    repeat (10) @(negedge clk);
    @(negedge clk); ptr_wr = 1; ptr_wdata = 'h1D0;
    @(negedge clk); ptr_wr = 0; go = 1;
    @(negedge clk); go = 0;
    chk(busy == 1, "R1 go while busy does not restart", 32'(busy), 1);
    wait_idle();
    chk(lmem[215] == 32'hC0DE_0007, "R1 running block finished", lmem[215], 32'hC0DE_0007);
    chk(n_dirq - d0 == 1, "R1 single completion", n_dirq - d0, 1);
  endtask

  task automatic t_abort();
    int w0, d0;
    lmem[252] = 32'hFEED;
    set_desc(0, 'h1A0, 'h300, 'h340, 64, 32'h1B0);
    set_desc(0, 'h1B0, 'h3F0, 'h3F0, 4, 32'h2);
    w0 = n_lwr; d0 = n_dirq;
    launch('h1A0);
    repeat (20) @(negedge clk);
    abort = 1; @(negedge clk); abort = 0;
    wait_idle();
    chk(done == 1, "R10 done after abort", 32'(done), 1);
    chk(n_lwr - w0 > 0 && n_lwr - w0 < 16, "R10 block cut short", n_lwr - w0, 16);
    chk(lmem[252] == 32'hFEED, "R10 next descriptor not processed", lmem[252], 32'hFEED);
    chk(n_dirq - d0 == 1, "R10 done_irq after abort", n_dirq - d0, 1);
  endtask

  task automatic t_done_clear();
    set_desc(0, 'h180, 'h200, 'h300, 0, 32'h2);
    launch('h180);
    chk(busy && !done, "R8 done cleared on accepted go", {busy, done}, 2);
    wait_idle();
    chk(done == 1, "R8 done set again", 32'(done), 1);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; finished = 0;
    ptr_wr = 0; ptr_wdata = '0; chain_mode = 1; enable = 1; go = 0; abort = 0; clr_cnt = 0;
    for (int i = 0; i < 256; i++) begin pmem[i] = '0; lmem[i] = '0; end
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_chain();
    t_zero();
    t_clear();
    t_ignore();
    t_abort();
    t_done_clear();
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end
endmodule